// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block guards a system against software that has stopped making progress. A free-running counter, clocked by the system clock, counts towards a timeout that software picks from sixteen power-of-two lengths. Software keeps the system alive by writing a restart key at regular intervals. If the timeout is reached anyway, the block does not reset the chip at once. It first sets a status flag and raises a fast-interrupt request, which gives a service routine a chance to recover. The routine acknowledges the request by clearing the flag. If the flag is still set when the following timeout arrives, the block issues a system reset pulse of fixed length.

Software reaches the block through a small synchronous register port with three registers. The configuration register holds the enable bit, the period field and a lock bit. The restart register accepts the key. The status register holds the flag. Once the lock bit is set, the configuration cannot change until the next reset. The reset pulse returns the block's own state to its reset values, just as the reset it triggers would.

Top module: `wdt_top`

## Requirements
- R1: After reset, irqOut and sysRstOut are low, the configuration register (address 0) reads 0, and the status register (address 2) reads 0.
- R2: The configuration register at address 0 has enable in bit 0, period n in bits 4:1 and lock in bit 5. With enable set, the first timeout falls 2^(BASE_LOG2+n) clock edges after the write that enabled the counter or last restarted it.
- R3: At the first timeout, status bit 0 (address 2) and irqOut go high. They stay high until software clears them or the reset pulse starts.
- R4: If the flag is still set at the next timeout, sysRstOut rises 2^(BASE_LOG2+n) edges after irqOut rose.
- R5: Writing a value with bit 0 set to the status register clears the flag, drops irqOut on the next cycle, and restarts the count.
- R6: sysRstOut stays high for exactly RST_PULSE cycles. When it starts, enable, period, lock and the flag all return to 0.
- R7: Writing RESTART_KEY to address 1 restarts the count. Any other value written there has no effect on the timing.
- R8: While the lock bit is set, writes to the configuration register are ignored. The lock is released only by a reset or by the block's own reset pulse.
- R9: While enable is 0, the counter is held and neither irqOut nor sysRstOut is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 2 | Read register address |
| rdData | output | DATA_W | Combinational read data |
| irqOut | output | 1 | Fast-interrupt request (level, equal to status flag) |
| sysRstOut | output | 1 | System reset request pulse |

## Verification
The bench builds the block with BASE_LOG2 = 4, which shortens the timeouts to 16, 64 and 512 cycles for periods 0, 2 and 5. At these lengths every timeout, both escalation stages, a complete reset pulse and the release of the lock all fit in a short run. Period length is measured to the exact edge from the enabling write, the restart write, the flag-clear write and the interrupt edge. This exposes any off-by-one in the terminal count or in the restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_KICK = 2'd1,
    REG_STAT = 2'd2
  } regSel_e;

  typedef struct packed {
    logic cntRun;
    logic cntClear;
  } cntStrobe_t;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PER_LSB = 1;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2   = 16,
  parameter int PERIOD_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cntStrobe_t             strobe,
  input  logic [PERIOD_BITS-1:0] periodSel,
  output logic                   expire
);

  localparam int MAXN = (1 << PERIOD_BITS) - 1;
  localparam int CW   = BASE_LOG2 + MAXN;

  logic [CW-1:0] count;
  logic [CW-1:0] limit;
  logic [CW-1:0] allOnes;
  logic [PERIOD_BITS-1:0] shiftAmt;

  always_comb begin
    allOnes  = '1;
    shiftAmt = PERIOD_BITS'(MAXN) - periodSel;
    limit    = allOnes >> shiftAmt;
    expire   = strobe.cntRun && (count == limit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntClear) begin
      count <= '0;
    end else if (strobe.cntRun) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int               PERIOD_BITS = 4,
  parameter int               DATA_W      = 16,
  parameter int               RST_PULSE   = 4,
  parameter logic [DATA_W-1:0] RESTART_KEY = 16'hC3A5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [1:0]             rdAddr,
  output logic [DATA_W-1:0]      rdData,
  input  logic                   expire,
  output cntStrobe_t             strobe,
  output logic [PERIOD_BITS-1:0] periodSel,
  output logic                   irqOut,
  output logic                   sysRstOut
);

  localparam int LOCK_BIT = CTRL_PER_LSB + PERIOD_BITS;
  localparam int PW       = $clog2(RST_PULSE + 1);

  logic          enable;
  logic          lock;
  logic          flag;
  logic [PW-1:0] pulseCnt;

  logic ctrlHit;
  logic kickHit;
  logic clearHit;

  always_comb begin
    ctrlHit  = wrEn && (wrAddr == REG_CTRL) && !lock;
    kickHit  = wrEn && (wrAddr == REG_KICK) && (wrData == RESTART_KEY);
    clearHit = wrEn && (wrAddr == REG_STAT) && wrData[0];
    strobe.cntRun   = enable;
    strobe.cntClear = !enable || expire || kickHit || clearHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      periodSel <= '0;
      lock      <= 1'b0;
      flag      <= 1'b0;
    end else if (expire) begin
      if (flag) begin
        enable    <= 1'b0;
        periodSel <= '0;
        lock      <= 1'b0;
        flag      <= 1'b0;
      end else begin
        flag <= 1'b1;
      end
    end else begin
      if (ctrlHit) begin
        enable    <= wrData[CTRL_EN_BIT];
        periodSel <= wrData[CTRL_PER_LSB +: PERIOD_BITS];
        lock      <= wrData[LOCK_BIT];
      end
      if (clearHit) begin
        flag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (expire && flag) begin
      pulseCnt <= PW'(RST_PULSE);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    irqOut    = flag;
    sysRstOut = (pulseCnt != '0);
    rdData    = '0;
    case (rdAddr)
      REG_CTRL: begin
        rdData[CTRL_EN_BIT]                  = enable;
        rdData[CTRL_PER_LSB +: PERIOD_BITS]  = periodSel;
        rdData[LOCK_BIT]                     = lock;
      end
      REG_STAT: rdData[0] = flag;
      default:  rdData    = '0;
    endcase
  end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int               BASE_LOG2   = 16,
  parameter int               PERIOD_BITS = 4,
  parameter int               DATA_W      = 16,
  parameter int               RST_PULSE   = 4,
  parameter logic [DATA_W-1:0] RESTART_KEY = 16'hC3A5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              sysRstOut
);

  cntStrobe_t             strobe;
  logic [PERIOD_BITS-1:0] periodSel;
  logic                   expire;

  wdt_ctrl #(
    .PERIOD_BITS(PERIOD_BITS),
    .DATA_W     (DATA_W),
    .RST_PULSE  (RST_PULSE),
    .RESTART_KEY(RESTART_KEY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .expire   (expire),
    .strobe   (strobe),
    .periodSel(periodSel),
    .irqOut   (irqOut),
    .sysRstOut(sysRstOut)
  );

  wdt_counter #(
    .BASE_LOG2  (BASE_LOG2),
    .PERIOD_BITS(PERIOD_BITS)
  ) u_cnt (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .periodSel(periodSel),
    .expire   (expire)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int DATA_W    = 16,
  parameter int RST_PULSE = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqOut,
  input logic              sysRstOut
);

  logic        prevRst;
  logic [31:0] hiRun;
  logic        clearWr;

  assign clearWr = wrEn && (wrAddr == 2'd2) && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRst <= 1'b0;
      hiRun   <= '0;
    end else begin
      prevRst <= sysRstOut;
      if (sysRstOut && !prevRst) hiRun <= 32'd1;
      else if (sysRstOut)        hiRun <= hiRun + 32'd1;
    end
  end

  // R3: flag persists until cleared or escalated
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !clearWr) |=> (irqOut || sysRstOut));

  // R4: reset only follows a pending interrupt
  a_r4_rst_after_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> $past(irqOut));

  // R5: clear write drops the interrupt
  a_r5_clear_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    clearWr |=> !irqOut);

  // R6: pulse length
  a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    (!sysRstOut && prevRst) |-> (hiRun == 32'(RST_PULSE)));

  // R6: flag is cleared while reset is asserted
  a_r6_no_irq_in_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> !irqOut);

endmodule

bind wdt_top wdt_checker #(
  .DATA_W   (DATA_W),
  .RST_PULSE(RST_PULSE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .irqOut   (irqOut),
  .sysRstOut(sysRstOut)
);

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;

  localparam int          BASE_LOG2 = 4;
  localparam int          RST_PULSE = 4;
  localparam logic [15:0] KEY       = 16'hC3A5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        irqOut;
  logic        sysRstOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  wdt_top #(
    .BASE_LOG2  (BASE_LOG2),
    .PERIOD_BITS(4),
    .DATA_W     (16),
    .RST_PULSE  (RST_PULSE),
    .RESTART_KEY(KEY)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut), .sysRstOut(sysRstOut)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irqOut && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic waitRst(output int n);
    n = 0;
    while (!sysRstOut && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check(irqOut == 1'b0, "R1 irq after reset", irqOut, 0);
    check(sysRstOut == 1'b0, "R1 rst after reset", sysRstOut, 0);
    readReg(2'd0, d); check(d == 16'h0, "R1 ctrl after reset", d, 0);
    readReg(2'd2, d); check(d == 16'h0, "R1 status after reset", d, 0);
  endtask

  task automatic t_period(input int n);
    int m;
    logic [15:0] d;
    doWrite(2'd0, 16'(1 + (n << 1)));
    waitIrq(m);
    check(m == (1 << (BASE_LOG2 + n)), "R2 first timeout", m, 1 << (BASE_LOG2 + n));
    readReg(2'd2, d); check(d == 16'h1, "R3 status flag set", d, 1);
    doWrite(2'd2, 16'h0001);
    check(irqOut == 1'b0, "R5 irq drops after clear", irqOut, 0);
    waitIrq(m);
    check(m == (1 << (BASE_LOG2 + n)), "R5 count restarted by clear", m, 1 << (BASE_LOG2 + n));
    doWrite(2'd2, 16'h0001);
    doWrite(2'd0, 16'h0000);
  endtask

  task automatic t_escalate();
    int m;
    logic [15:0] d;
    doWrite(2'd0, 16'h0001);
    waitIrq(m);
    check(m == 16, "R3 irq before escalation", m, 16);
    waitRst(m);
    check(m == 16, "R4 reset one period after irq", m, 16);
    m = 0;
    while (sysRstOut && m < 100) begin m++; @(negedge clk); end
    check(m == RST_PULSE, "R6 reset pulse width", m, RST_PULSE);
    readReg(2'd0, d); check(d == 16'h0, "R6 ctrl cleared by pulse", d, 0);
    readReg(2'd2, d); check(d == 16'h0, "R6 flag cleared by pulse", d, 0);
  endtask

  task automatic t_key();
    int m;
    doWrite(2'd0, 16'h0003);
    repeat (20) @(negedge clk);
    doWrite(2'd1, 16'h1234);
    waitIrq(m);
    check(m + 21 == 32, "R7 wrong key ignored", m + 21, 32);
    doWrite(2'd2, 16'h0001);
    repeat (20) @(negedge clk);
    check(irqOut == 1'b0, "R7 no irq before key", irqOut, 0);
    doWrite(2'd1, KEY);
    waitIrq(m);
    check(m == 32, "R7 key restarts count", m, 32);
    doWrite(2'd2, 16'h0001);
    doWrite(2'd0, 16'h0000);
  endtask

  task automatic t_lock();
    int m;
    logic [15:0] d;
    doWrite(2'd0, 16'h0021);
    readReg(2'd0, d); check(d == 16'h0021, "R8 lock readback", d, 16'h21);
    doWrite(2'd0, 16'h0000);
    readReg(2'd0, d); check(d == 16'h0021, "R8 locked write ignored", d, 16'h21);
    waitIrq(m);
    check(m + 1 == 16, "R8 counting continues when locked", m + 1, 16);
    waitRst(m);
    while (sysRstOut) @(negedge clk);
    readReg(2'd0, d); check(d == 16'h0, "R8 lock released by pulse", d, 0);
    doWrite(2'd0, 16'h0003);
    readReg(2'd0, d); check(d == 16'h0003, "R8 writes accepted after release", d, 3);
    doWrite(2'd0, 16'h0000);
  endtask

  task automatic t_disabled();
    int seen = 0;
    doWrite(2'd0, 16'h0002);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (irqOut || sysRstOut) seen++;
    end
    check(seen == 0, "R9 disabled stays quiet", seen, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_period(0);
    t_period(2);
    t_period(5);
    t_escalate();
    t_key();
    t_lock();
    t_disabled();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finishRun();
  end

endmodule